// File: doc/BRIEF.md
# Coprocessor Card Host Register Interface

This block is the host-facing side of a communication coprocessor card. On the host I/O bus it looks like one device with two registers: a write-only command word and a read-only status word. The command word holds the lines that keep the local processor in reset or halted, a power-low indication and a check-bit write disable. It also fires single-cycle doorbell pulses toward the local processor. Only the host can reset or halt the local processor.

In the other direction, the local side reports a status change with a one-cycle pulse. The block latches that pulse into a flag. While the flag and its enable bit are both set, the block holds an interrupt request to the host. The request carries a fixed priority level of 12. The status word reports the enable, the flag, the reset and halt lines, and an 8-bit common-memory bank number built from two 4-bit switch inputs. Each bank step covers 128 Kbytes.

An access is one strobe cycle carrying address, direction and write data. Writes take effect at that clock edge. Read data is registered and is valid in the cycle after the strobe. At all other times the read data bus is zero.

Top module: `hostctl_regif`

## Requirements
- R1: After reset, `loc_reset` is 1. `loc_halt`, `power_low`, `chk_wr_dis`, the three doorbells, `host_irq` and `acc_rdata` are all 0.
- R2: A write strobe at offset 3 loads command bits 4 (reset), 5 (halt), 6 (power low) and 8 (check-bit write disable) onto `loc_reset`, `loc_halt`, `power_low` and `chk_wr_dis`. The new values appear in the cycle after the strobe and are held until the next offset-3 write.
- R3: Command bits 2, 3 and 7, written as 1 at offset 3, pulse `db_calling`, `db_opcom` and `db_ready` respectively. Each pulse lasts exactly one cycle, in the cycle after the strobe, and the bits are not stored.
- R4: A one-cycle `loc_status_chg` pulse sets the status-change flag in the next cycle. The flag stays set through any number of idle cycles.
- R5: An offset-3 write with bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves it set. If a status-change pulse and a clearing write fall in the same cycle, the flag ends up set.
- R6: `host_irq` is high exactly while the flag and the enable (command bit 0) are both set. It holds at level until the flag or the enable is cleared.
- R7: A read strobe at offset 2 returns the status word in the cycle after the strobe. Bit 0 is the enable, bit 2 the flag, bit 4 reset, bit 5 halt, and bits 1, 3, 6 and 7 are 0. In every other cycle `acc_rdata` is 0.
- R8: Status bits 15:8 hold the bank number, with `sw_bank_hi` in bits 15:12 and `sw_bank_lo` in bits 11:8, sampled on the read strobe.
- R9: Writes to any offset other than 3, and writes to command bits 1 and 9 to 15, change no output.
- R10: `irq_lvl` reports the constant host interrupt level 12.
- R11: A read strobe at any offset other than 2 returns 0 and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_stb | input | 1 | Register access strobe, one cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 2 | Register offset within the device |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Read data, valid the cycle after a read strobe |
| sw_bank_lo | input | 4 | Bank number switch, low nibble |
| sw_bank_hi | input | 4 | Bank number switch, high nibble |
| loc_status_chg | input | 1 | Status-change pulse from the local side |
| loc_reset | output | 1 | Holds local processor in reset |
| loc_halt | output | 1 | Holds local processor halted |
| power_low | output | 1 | Power-low indication to the card |
| chk_wr_dis | output | 1 | Disables check-bit writes |
| db_calling | output | 1 | Host-calling doorbell pulse |
| db_opcom | output | 1 | Operator-communication start pulse |
| db_ready | output | 1 | Host-ready doorbell pulse |
| host_irq | output | 1 | Interrupt request to host, level |
| irq_lvl | output | 4 | Host interrupt level |

## Verification
The bench drives a status-change pulse and a clearing write in the same cycle. A design that let the clear win would drop an event the host never saw. It checks that a write with bit 0 set leaves the flag alone, and that a masked flag still shows in the status word and raises the interrupt as soon as the enable is written. A design that stored the flag only while enabled, or treated every write as a clear, fails one of these. It also confirms that doorbells last one cycle and never read back, that reserved status bits stay 0 after an all-ones write, and that strobes at the wrong offset leave every held line untouched.

// File: rtl/hostctl_pkg.sv
package hostctl_pkg;

   // command word bit positions
   localparam int CB_SC_EN  = 0;
   localparam int CB_CALL   = 2;
   localparam int CB_OPCOM  = 3;
   localparam int CB_RST    = 4;
   localparam int CB_HALT   = 5;
   localparam int CB_PWRLO  = 6;
   localparam int CB_READY  = 7;
   localparam int CB_CHKDIS = 8;

   // status word bit positions
   localparam int SB_SC_EN   = 0;
   localparam int SB_SC_FLAG = 2;
   localparam int SB_RST     = 4;
   localparam int SB_HALT    = 5;
   localparam int SB_BANK    = 8;

   typedef struct packed {
      logic chk_dis;
      logic pwr_lo;
      logic halt;
      logic rst;
      logic sc_en;
   } hold_t;

   typedef struct packed {
      logic ready;
      logic opcom;
      logic calling;
   } bell_t;

endpackage

// File: rtl/hostctl_ctrl_reg.sv
module hostctl_ctrl_reg
   import hostctl_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  wr_hit,
   input  hold_t hold_d,
   input  bell_t bell_d,
   output hold_t hold_q,
   output bell_t bell_q
);

   localparam hold_t HOLD_RST = '{chk_dis: 1'b0, pwr_lo: 1'b0, halt: 1'b0,
                                  rst: 1'b1, sc_en: 1'b0};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= HOLD_RST;
         bell_q <= '0;
      end else begin
         if (wr_hit) hold_q <= hold_d;
         bell_q <= wr_hit ? bell_d : '0;
      end
   end

   // R9: held lines move only after a command write
   a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_hit) |-> $stable(hold_q));

   // R3: any doorbell pulse comes from a write one cycle earlier
   a_r3_bell_source: assert property (@(posedge clk) disable iff (!rst_n)
      (bell_q != '0) |-> $past(wr_hit));

endmodule

// File: rtl/hostctl_sc_irq.sv
module hostctl_sc_irq #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sc_pulse,
   input  logic sc_clr,
   input  logic wr_hit,
   input  logic sc_en,
   output logic sc_flag,
   output logic host_irq
);

   logic flag_d;

   generate
      if (SET_WINS) begin : g_set_wins
         assign flag_d = sc_pulse | (sc_flag & ~sc_clr);

         // R5: a new event survives a simultaneous clear
         a_r5_set_priority: assert property (@(posedge clk) disable iff (!rst_n)
            sc_pulse |=> sc_flag);
      end else begin : g_clr_wins
         assign flag_d = ~sc_clr & (sc_flag | sc_pulse);

         a_r4_set_no_clr: assert property (@(posedge clk) disable iff (!rst_n)
            (sc_pulse && !sc_clr) |=> sc_flag);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sc_flag <= 1'b0;
      else        sc_flag <= flag_d;
   end

   assign host_irq = sc_flag & sc_en;

   // R5: the flag only drops after a clearing write
   a_r5_clear_source: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sc_flag) && !sc_flag) |-> $past(sc_clr));

   // R6: the request holds until a command write changes flag or enable
   a_r6_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(host_irq) && !host_irq) |-> $past(wr_hit));

endmodule

// File: rtl/hostctl_stat_rd.sv
module hostctl_stat_rd
   import hostctl_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int BANK_NIB_W = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_hit,
   input  hold_t                 hold_q,
   input  logic                  sc_flag,
   input  logic [BANK_NIB_W-1:0] bank_lo,
   input  logic [BANK_NIB_W-1:0] bank_hi,
   output logic [DATA_W-1:0]     rdata
);

   localparam int BANK_W = 2 * BANK_NIB_W;

   generate
      if (DATA_W < SB_BANK + BANK_W) begin : g_bad_width
         $error("status word too narrow for the bank field");
      end
   endgenerate

   logic [DATA_W-1:0] stat_w;

   always_comb begin
      stat_w                      = '0;
      stat_w[SB_SC_EN]            = hold_q.sc_en;
      stat_w[SB_SC_FLAG]          = sc_flag;
      stat_w[SB_RST]              = hold_q.rst;
      stat_w[SB_HALT]             = hold_q.halt;
      stat_w[SB_BANK +: BANK_W]   = {bank_hi, bank_lo};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rdata <= '0;
      else        rdata <= rd_hit ? stat_w : '0;
   end

   // R7: the bus is quiet outside the cycle after a status read
   a_r7_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_hit) |-> (rdata == '0));

endmodule

// File: rtl/hostctl_regif.sv
module hostctl_regif
   import hostctl_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 2,
   parameter int CTRL_OFS   = 3,
   parameter int STAT_OFS   = 2,
   parameter int BANK_NIB_W = 4,
   parameter int IRQ_LVL_W  = 4,
   parameter int IRQ_LVL    = 12,
   parameter bit SET_WINS   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_stb,
   input  logic                  acc_wr,
   input  logic [ADDR_W-1:0]     acc_addr,
   input  logic [DATA_W-1:0]     acc_wdata,
   output logic [DATA_W-1:0]     acc_rdata,
   input  logic [BANK_NIB_W-1:0] sw_bank_lo,
   input  logic [BANK_NIB_W-1:0] sw_bank_hi,
   input  logic                  loc_status_chg,
   output logic                  loc_reset,
   output logic                  loc_halt,
   output logic                  power_low,
   output logic                  chk_wr_dis,
   output logic                  db_calling,
   output logic                  db_opcom,
   output logic                  db_ready,
   output logic                  host_irq,
   output logic [IRQ_LVL_W-1:0]  irq_lvl
);

   localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);
   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);

   generate
      if (CTRL_OFS == STAT_OFS) begin : g_bad_ofs
         $error("command and status offsets must differ");
      end
      if (DATA_W <= CB_CHKDIS) begin : g_bad_cmd
         $error("command word too narrow");
      end
      if (IRQ_LVL >= (1 << IRQ_LVL_W)) begin : g_bad_lvl
         $error("interrupt level does not fit its field");
      end
   endgenerate

   logic  wr_hit, rd_hit, sc_flag, sc_clr;
   hold_t hold_d, hold_q;
   bell_t bell_d, bell_q;
   logic  unused_wbits;

   assign wr_hit = acc_stb &  acc_wr & (acc_addr == CTRL_A);
   assign rd_hit = acc_stb & ~acc_wr & (acc_addr == STAT_A);
   assign sc_clr = wr_hit & ~acc_wdata[CB_SC_EN];
   assign unused_wbits = ^acc_wdata;

   assign hold_d = '{chk_dis: acc_wdata[CB_CHKDIS], pwr_lo: acc_wdata[CB_PWRLO],
                     halt: acc_wdata[CB_HALT], rst: acc_wdata[CB_RST],
                     sc_en: acc_wdata[CB_SC_EN]};
   assign bell_d = '{ready: acc_wdata[CB_READY], opcom: acc_wdata[CB_OPCOM],
                     calling: acc_wdata[CB_CALL]};

   hostctl_ctrl_reg u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit),
      .hold_d (hold_d),
      .bell_d (bell_d),
      .hold_q (hold_q),
      .bell_q (bell_q)
   );

   hostctl_sc_irq #(.SET_WINS(SET_WINS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sc_pulse (loc_status_chg),
      .sc_clr   (sc_clr),
      .wr_hit   (wr_hit),
      .sc_en    (hold_q.sc_en),
      .sc_flag  (sc_flag),
      .host_irq (host_irq)
   );

   hostctl_stat_rd #(.DATA_W(DATA_W), .BANK_NIB_W(BANK_NIB_W)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_hit  (rd_hit),
      .hold_q  (hold_q),
      .sc_flag (sc_flag),
      .bank_lo (sw_bank_lo),
      .bank_hi (sw_bank_hi),
      .rdata   (acc_rdata)
   );

   assign loc_reset  = hold_q.rst;
   assign loc_halt   = hold_q.halt;
   assign power_low  = hold_q.pwr_lo;
   assign chk_wr_dis = hold_q.chk_dis;
   assign db_calling = bell_q.calling;
   assign db_opcom   = bell_q.opcom;
   assign db_ready   = bell_q.ready;
   assign irq_lvl    = IRQ_LVL_W'(IRQ_LVL);

   // R2: the reset line only moves after a command write
   a_r2_reset_by_write: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_reset != $past(loc_reset)) |-> $past(wr_hit));

   // R11: a strobe at a wrong offset leaves the read bus quiet
   a_r11_other_read: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_stb && !acc_wr && acc_addr != STAT_A) |=> (acc_rdata == '0));

endmodule

// File: tb/hostctl_regif_bench.sv
module hostctl_regif_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_stb = 1'b0, acc_wr = 1'b0;
   logic [1:0]  acc_addr = '0;
   logic [15:0] acc_wdata = '0;
   logic [15:0] acc_rdata;
   logic [3:0]  sw_bank_lo = 4'h5, sw_bank_hi = 4'hA;
   logic        loc_status_chg = 1'b0;
   logic        loc_reset, loc_halt, power_low, chk_wr_dis;
   logic        db_calling, db_opcom, db_ready, host_irq;
   logic [3:0]  irq_lvl;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   hostctl_regif u_hostctl_regif (
      .clk(clk), .rst_n(rst_n), .acc_stb(acc_stb), .acc_wr(acc_wr),
      .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .sw_bank_lo(sw_bank_lo), .sw_bank_hi(sw_bank_hi),
      .loc_status_chg(loc_status_chg), .loc_reset(loc_reset),
      .loc_halt(loc_halt), .power_low(power_low), .chk_wr_dis(chk_wr_dis),
      .db_calling(db_calling), .db_opcom(db_opcom), .db_ready(db_ready),
      .host_irq(host_irq), .irq_lvl(irq_lvl)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // held lines packed as {chk_wr_dis, power_low, loc_halt, loc_reset}
   function automatic logic [3:0] held();
      return {chk_wr_dis, power_low, loc_halt, loc_reset};
   endfunction

   function automatic logic [2:0] bells();
      return {db_ready, db_opcom, db_calling};
   endfunction

   // one strobe; returns at the negedge after the capturing edge
   task automatic access(bit wr, logic [1:0] a, logic [15:0] d);
      @(negedge clk);
      acc_stb = 1'b1; acc_wr = wr; acc_addr = a; acc_wdata = d;
      @(negedge clk);
      acc_stb = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
   endtask

   task automatic pulse_chg();
      @(negedge clk);
      loc_status_chg = 1'b1;
      @(negedge clk);
      loc_status_chg = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 held", {28'd0, held()}, 32'h1);
      chk("R1 bells", {29'd0, bells()}, 32'h0);
      chk("R1 irq", {31'd0, host_irq}, 32'h0);
      chk("R1 rdata", {16'd0, acc_rdata}, 32'h0);
      chk("R10 level", {28'd0, irq_lvl}, 32'd12);
   endtask

   task automatic t_held();
      access(1'b1, 2'd3, 16'h0170);
      chk("R2 all held set", {28'd0, held()}, 32'hF);
      @(negedge clk);
      chk("R2 held kept", {28'd0, held()}, 32'hF);
      access(1'b1, 2'd3, 16'h0040);
      chk("R2 only power low", {28'd0, held()}, 32'h4);
   endtask

   task automatic t_bells();
      access(1'b1, 2'd3, 16'h0084);
      chk("R3 calling+ready pulse", {29'd0, bells()}, 32'h5);
      @(negedge clk);
      chk("R3 pulse ends", {29'd0, bells()}, 32'h0);
      access(1'b1, 2'd3, 16'h0008);
      chk("R3 opcom pulse", {29'd0, bells()}, 32'h2);
      chk("R3 bells leave held", {28'd0, held()}, 32'h0);
      @(negedge clk);
      chk("R3 opcom ends", {29'd0, bells()}, 32'h0);
   endtask

   task automatic t_flag();
      access(1'b1, 2'd3, 16'h0001);
      chk("R6 no flag no irq", {31'd0, host_irq}, 32'h0);
      pulse_chg();
      chk("R6 irq raised", {31'd0, host_irq}, 32'h1);
      repeat (3) @(negedge clk);
      chk("R4 flag persists", {31'd0, host_irq}, 32'h1);
      access(1'b0, 2'd2, 16'h0);
      chk("R7 status en+flag", {16'd0, acc_rdata}, 32'hA505);
      @(negedge clk);
      chk("R7 rdata back to 0", {16'd0, acc_rdata}, 32'h0);
      access(1'b1, 2'd3, 16'h0001);
      chk("R5 bit0=1 keeps flag", {31'd0, host_irq}, 32'h1);
      access(1'b1, 2'd3, 16'h0000);
      chk("R5 cleared irq", {31'd0, host_irq}, 32'h0);
      access(1'b0, 2'd2, 16'h0);
      chk("R5 flag cleared", {16'd0, acc_rdata}, 32'hA500);
   endtask

   task automatic t_masked();
      pulse_chg();
      chk("R6 masked no irq", {31'd0, host_irq}, 32'h0);
      access(1'b0, 2'd2, 16'h0);
      chk("R7 masked flag visible", {16'd0, acc_rdata}, 32'hA504);
      access(1'b1, 2'd3, 16'h0001);
      chk("R6 enable raises irq", {31'd0, host_irq}, 32'h1);
      access(1'b1, 2'd3, 16'h0000);
   endtask

   task automatic t_simul();
      access(1'b1, 2'd3, 16'h0001);
      @(negedge clk);
      loc_status_chg = 1'b1;
      acc_stb = 1'b1; acc_wr = 1'b1; acc_addr = 2'd3; acc_wdata = 16'h0000;
      @(negedge clk);
      loc_status_chg = 1'b0; acc_stb = 1'b0; acc_wr = 1'b0;
      access(1'b0, 2'd2, 16'h0);
      chk("R5 set beats clear", {16'd0, acc_rdata}, 32'hA504);
      access(1'b1, 2'd3, 16'h0000);
   endtask

   task automatic t_bank_reserved();
      access(1'b1, 2'd3, 16'h0030);
      access(1'b0, 2'd2, 16'h0);
      chk("R8 bank A5", {16'd0, acc_rdata}, 32'hA530);
      @(negedge clk);
      sw_bank_lo = 4'hF; sw_bank_hi = 4'h3;
      access(1'b0, 2'd2, 16'h0);
      chk("R8 bank 3F", {16'd0, acc_rdata}, 32'h3F30);
      access(1'b1, 2'd3, 16'hFFFF);
      chk("R9 unused bits ignored", {28'd0, held()}, 32'hF);
      access(1'b0, 2'd2, 16'h0);
      chk("R7 reserved bits zero", {16'd0, acc_rdata}, 32'h3F31);
      access(1'b1, 2'd3, 16'h0000);
   endtask

   task automatic t_wrong_offset();
      access(1'b1, 2'd3, 16'h0060);
      access(1'b1, 2'd2, 16'hFFFF);
      chk("R9 offset2 write held", {28'd0, held()}, 32'h6);
      chk("R9 offset2 write bells", {29'd0, bells()}, 32'h0);
      access(1'b1, 2'd0, 16'h01BD);
      chk("R9 offset0 write held", {28'd0, held()}, 32'h6);
      chk("R9 offset0 write bells", {29'd0, bells()}, 32'h0);
      access(1'b0, 2'd3, 16'h0);
      chk("R11 read offset3 zero", {16'd0, acc_rdata}, 32'h0);
      chk("R11 read keeps held", {28'd0, held()}, 32'h6);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_held();
      t_bells();
      t_flag();
      t_masked();
      t_simul();
      t_bank_reserved();
      t_wrong_offset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #50000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule